// File: doc/BRIEF.md
# Indirect address modification chain sequencer

This block resolves the effective address of one instruction by walking its chain of address modifications. The instruction's 6-bit tag is split into a 2-bit mode and a 4-bit designator. The block then applies register, register-then-indirect or indirect-then-register modification until the chain ends. Each indirect step reads one 36-bit word over a request/acknowledge port. The upper 18 bits of that word become the new address and its low 6 bits become the new tag.

Indirect-then-register steps save a held designator. That designator is applied only when the chain reaches a plain register word. Tally-type tags met in plain decoding are passed to an external tally handler, and the block resumes when the handler completes. A fetch counter stops runaway chains with a lockup fault. One done or fault pulse ends each instruction, and the block is then ready for the next start.

Top module: `addr_chain_seq`

## Requirements
- R1: After reset, `done_o`, `fault_o`, `mem_req_o` and `tally_vld_o` are low. A start is accepted only while the block is idle.
- R2: Tag bits [5:4] give the mode: 0 register, 1 register-then-indirect, 2 tally, 3 indirect-then-register. Tag bits [3:0] give the designator, which selects the modifier: 0 none (zero), 1 A upper half, 2 Q upper half, 3 direct upper, 4 instruction counter, 5 A lower half, 6 Q lower half, 7 direct lower, 8–15 index register 0–7. Every address sum wraps modulo 2^18.
- R3: In register mode the block pulses `done_o` with `ea_o` equal to the address plus the modifier. A direct designator (3 or 7) leaves the address unchanged and raises `direct_o`.
- R4: Register-then-indirect mode fetches the word at address plus modifier. It takes word bits [35:18] as the address and bits [5:0] as the tag, then decodes again.
- R5: Indirect-then-register mode fetches at the current address and holds the current designator. When the fetched word carries a register-mode tag, the next step decodes register mode with the held designator and the fetched address.
- R6: When a fetched word in the indirect-then-register path carries a register-then-indirect tag, the block adds that tag's modifier and fetches again, keeping the held designator.
- R7: When a fetched word in the indirect-then-register path carries an indirect-then-register tag, that tag's designator replaces the held one and the block fetches at the fetched address.
- R8: When a fetched word in the indirect-then-register path carries a tally tag with designator 6 or 7, the block ends with `fault_o`, fault code 2 or 3 respectively, and `ea_o` equal to the address just fetched. Other tally designators in that path act as a register-mode tag.
- R9: A chain never makes more than STEP_LIMIT fetches. If one more fetch would be needed, the block ends with fault code 1. A chain that ends on its STEP_LIMIT-th fetch is not a lockup.
- R10: With `repeat_i` set, register-then-indirect mode performs one fetch and ends with `ea_o` equal to the fetched address, without decoding again.
- R11: A tally tag reached by decoding raises `tally_vld_o`, which presents the address, the tag and the last fetched word and stays high until `tally_done_i`. The block then pulses `done_o` with `ea_o` equal to `tally_ea_i`.
- R12: A direct designator in register-then-indirect mode, whether on the instruction or on a word fetched in the indirect-then-register path, ends with fault code 4.
- R13: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_ack_i`. Done and fault pulses last one cycle, are never high together, and return the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin resolving one instruction |
| addr_i | input | AW | Instruction address field |
| tag_i | input | 6 | Instruction tag |
| repeat_i | input | 1 | Instruction is of repeat type |
| a_i | input | WW | A register |
| q_i | input | WW | Q register |
| x_i | input | 8*AW | Index registers 0–7, register k at bits [k*AW +: AW] |
| ic_i | input | AW | Instruction counter |
| mem_req_o | output | 1 | Indirect word read request |
| mem_addr_o | output | AW | Indirect word address |
| mem_ack_i | input | 1 | Read data valid |
| mem_data_i | input | WW | Indirect word |
| tally_vld_o | output | 1 | Tally handoff request |
| tally_addr_o | output | AW | Tally handoff address |
| tally_tag_o | output | 6 | Tally handoff tag |
| tally_word_o | output | WW | Last fetched indirect word |
| tally_done_i | input | 1 | Tally handler finished |
| tally_ea_i | input | AW | Address produced by tally handler |
| done_o | output | 1 | Chain resolved (one-cycle pulse) |
| fault_o | output | 1 | Chain faulted (one-cycle pulse) |
| fault_code_o | output | 3 | 1 lockup, 2 F2, 3 F3, 4 illegal modifier |
| ea_o | output | AW | Resolved or faulting address |
| direct_o | output | 1 | Direct operand designator ended the chain |

## Verification
Two checks can meet on one acknowledge: the lockup guard and the end of the chain. On the STEP_LIMIT-th fetch, the fetched tag can either finish the chain or fault it, or it can demand one more fetch. The bench builds indirect-then-register chains exactly STEP_LIMIT words long with a small limit. It ends the chain once with a tally F2 tag and once with another indirect-then-register tag. It expects fault code 2 at the last fetched address in the first case and fault code 1 in the second, with exactly STEP_LIMIT fetches counted at the memory port both times. A register-then-indirect chain of the same length that ends normally, and one a word longer, bracket the same boundary.

// File: rtl/addr_chain_pkg.sv
package addr_chain_pkg;
  localparam int TAG_W = 6;
  localparam int TD_W  = 4;
  localparam int NUM_X = 8;

  typedef enum logic [1:0] {
    MODE_REG     = 2'd0,
    MODE_REG_IND = 2'd1,
    MODE_TALLY   = 2'd2,
    MODE_IND_REG = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_LOCKUP = 3'd1,
    FLT_F2     = 3'd2,
    FLT_F3     = 3'd3,
    FLT_ILLMOD = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    S_IDLE, S_DECODE, S_FETCH, S_TALLY
  } state_e;

  localparam logic [TD_W-1:0] TD_NONE = 4'd0;
  localparam logic [TD_W-1:0] TD_DU   = 4'd3;
  localparam logic [TD_W-1:0] TD_DL   = 4'd7;
  localparam logic [TD_W-1:0] TD_F2   = 4'd6;
  localparam logic [TD_W-1:0] TD_F3   = 4'd7;
endpackage

// File: rtl/chain_mod_adder.sv
module chain_mod_adder
  import addr_chain_pkg::*;
#(
  parameter int AW = 18,
  parameter int WW = 36
) (
  input  logic [TD_W-1:0]     td_i,
  input  logic [AW-1:0]       base_i,
  input  logic [WW-1:0]       a_i,
  input  logic [WW-1:0]       q_i,
  input  logic [NUM_X*AW-1:0] x_i,
  input  logic [AW-1:0]       ic_i,
  output logic [AW-1:0]       sum_o,
  output logic                direct_o
);
  logic [AW-1:0] xr [NUM_X];
  logic [AW-1:0] mod_val;

  for (genvar g = 0; g < NUM_X; g++) begin : g_xr
    assign xr[g] = x_i[g*AW +: AW];
  end

  always_comb begin
    if (td_i[3]) begin
      mod_val = xr[td_i[2:0]];
    end else begin
      unique case (td_i[2:0])
        3'd1:    mod_val = a_i[WW-1 -: AW];
        3'd2:    mod_val = q_i[WW-1 -: AW];
        3'd4:    mod_val = ic_i;
        3'd5:    mod_val = a_i[AW-1:0];
        3'd6:    mod_val = q_i[AW-1:0];
        default: mod_val = '0;  // none, direct upper, direct lower
      endcase
    end
  end

  assign direct_o = (td_i == TD_DU) || (td_i == TD_DL);
  assign sum_o    = base_i + mod_val;
endmodule

// File: rtl/chain_step_guard.sv
module chain_step_guard #(
  parameter int LIMIT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_limit_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign at_limit_o = (cnt_q == CW'(LIMIT));
endmodule

// File: rtl/addr_chain_seq.sv
module addr_chain_seq
  import addr_chain_pkg::*;
#(
  parameter int AW         = 18,
  parameter int WW         = 36,
  parameter int STEP_LIMIT = 4096
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [TAG_W-1:0]    tag_i,
  input  logic                repeat_i,
  input  logic [WW-1:0]       a_i,
  input  logic [WW-1:0]       q_i,
  input  logic [NUM_X*AW-1:0] x_i,
  input  logic [AW-1:0]       ic_i,
  output logic                mem_req_o,
  output logic [AW-1:0]       mem_addr_o,
  input  logic                mem_ack_i,
  input  logic [WW-1:0]       mem_data_i,
  output logic                tally_vld_o,
  output logic [AW-1:0]       tally_addr_o,
  output logic [TAG_W-1:0]    tally_tag_o,
  output logic [WW-1:0]       tally_word_o,
  input  logic                tally_done_i,
  input  logic [AW-1:0]       tally_ea_i,
  output logic                done_o,
  output logic                fault_o,
  output logic [2:0]          fault_code_o,
  output logic [AW-1:0]       ea_o,
  output logic                direct_o
);
  state_e           state_q;
  logic [AW-1:0]    ca_q;
  logic [TAG_W-1:0] tag_q;
  logic [TD_W-1:0]  hold_q;
  logic [WW-1:0]    word_q;
  logic             rep_q, ir_q, direct_q, done_q, fault_q;
  fault_e           code_q;

  logic             fetching, ack, accept;
  logic [AW-1:0]    w_addr;
  logic [TAG_W-1:0] w_tag;
  mode_e            cur_mode, w_mode;
  logic [TD_W-1:0]  add_td;
  logic [AW-1:0]    add_base, add_sum, nxt_addr;
  logic             add_direct, want_fetch, at_limit, go_fetch, lock_hit;

  assign fetching = (state_q == S_FETCH);
  assign ack      = fetching && mem_ack_i;
  assign accept   = (state_q == S_IDLE) && start_i;
  assign w_addr   = mem_data_i[WW-1 -: AW];
  assign w_tag    = mem_data_i[TAG_W-1:0];
  assign cur_mode = mode_e'(tag_q[5:4]);
  assign w_mode   = mode_e'(w_tag[5:4]);
  // Fetched word's designator while in fetch, own tag otherwise
  assign add_td   = fetching ? w_tag[TD_W-1:0] : tag_q[TD_W-1:0];
  assign add_base = fetching ? w_addr : ca_q;

  chain_mod_adder #(.AW(AW), .WW(WW)) u_adder (
    .td_i(add_td), .base_i(add_base), .a_i(a_i), .q_i(q_i), .x_i(x_i),
    .ic_i(ic_i), .sum_o(add_sum), .direct_o(add_direct)
  );

  always_comb begin
    want_fetch = 1'b0;
    nxt_addr   = ca_q;
    unique case (state_q)
      S_DECODE: begin
        if (cur_mode == MODE_REG_IND && !add_direct) begin
          want_fetch = 1'b1;
          nxt_addr   = add_sum;
        end else if (cur_mode == MODE_IND_REG) begin
          want_fetch = 1'b1;
        end
      end
      S_FETCH: begin
        if (mem_ack_i && ir_q) begin
          if (w_mode == MODE_REG_IND && !add_direct) begin
            want_fetch = 1'b1;
            nxt_addr   = add_sum;
          end else if (w_mode == MODE_IND_REG) begin
            want_fetch = 1'b1;
            nxt_addr   = w_addr;
          end
        end
      end
      default: ;
    endcase
  end

  assign go_fetch = want_fetch && !at_limit;
  assign lock_hit = want_fetch && at_limit;

  chain_step_guard #(.LIMIT(STEP_LIMIT)) u_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept), .inc_i(go_fetch),
    .at_limit_o(at_limit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      ca_q     <= '0;
      tag_q    <= '0;
      hold_q   <= '0;
      word_q   <= '0;
      rep_q    <= 1'b0;
      ir_q     <= 1'b0;
      direct_q <= 1'b0;
      done_q   <= 1'b0;
      fault_q  <= 1'b0;
      code_q   <= FLT_NONE;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start_i) begin
            ca_q     <= addr_i;
            tag_q    <= tag_i;
            hold_q   <= '0;
            word_q   <= '0;
            rep_q    <= repeat_i;
            direct_q <= 1'b0;
            code_q   <= FLT_NONE;
            state_q  <= S_DECODE;
          end
        end
        S_DECODE: begin
          if (lock_hit) begin
            code_q <= FLT_LOCKUP; fault_q <= 1'b1; state_q <= S_IDLE;
          end else begin
            unique case (cur_mode)
              MODE_REG: begin
                if (add_direct) direct_q <= 1'b1;
                else            ca_q     <= add_sum;
                done_q  <= 1'b1;
                state_q <= S_IDLE;
              end
              MODE_REG_IND: begin
                if (add_direct) begin
                  code_q <= FLT_ILLMOD; fault_q <= 1'b1; state_q <= S_IDLE;
                end else begin
                  ca_q <= nxt_addr; ir_q <= 1'b0; state_q <= S_FETCH;
                end
              end
              MODE_TALLY: state_q <= S_TALLY;
              MODE_IND_REG: begin
                hold_q  <= tag_q[TD_W-1:0];
                ir_q    <= 1'b1;
                state_q <= S_FETCH;
              end
            endcase
          end
        end
        S_FETCH: begin
          if (mem_ack_i) begin
            word_q <= mem_data_i;
            if (!ir_q) begin
              ca_q    <= w_addr;
              tag_q   <= w_tag;
              if (rep_q) begin
                done_q <= 1'b1; state_q <= S_IDLE;
              end else begin
                state_q <= S_DECODE;
              end
            end else begin
              unique case (w_mode)
                MODE_REG_IND: begin
                  if (add_direct) begin
                    code_q <= FLT_ILLMOD; fault_q <= 1'b1; state_q <= S_IDLE;
                  end else if (lock_hit) begin
                    code_q <= FLT_LOCKUP; fault_q <= 1'b1; state_q <= S_IDLE;
                  end else begin
                    ca_q <= nxt_addr;
                  end
                end
                MODE_IND_REG: begin
                  if (lock_hit) begin
                    code_q <= FLT_LOCKUP; fault_q <= 1'b1; state_q <= S_IDLE;
                  end else begin
                    hold_q <= w_tag[TD_W-1:0];
                    ca_q   <= nxt_addr;
                  end
                end
                MODE_TALLY: begin
                  // ca_q keeps the fetch address on the fault exits
                  if (w_tag[TD_W-1:0] == TD_F2) begin
                    code_q <= FLT_F2; fault_q <= 1'b1; state_q <= S_IDLE;
                  end else if (w_tag[TD_W-1:0] == TD_F3) begin
                    code_q <= FLT_F3; fault_q <= 1'b1; state_q <= S_IDLE;
                  end else begin
                    ca_q    <= w_addr;
                    tag_q   <= {MODE_REG, hold_q};
                    state_q <= S_DECODE;
                  end
                end
                default: begin
                  ca_q    <= w_addr;
                  tag_q   <= {MODE_REG, hold_q};
                  state_q <= S_DECODE;
                end
              endcase
            end
          end
        end
        S_TALLY: begin
          if (tally_done_i) begin
            ca_q <= tally_ea_i; done_q <= 1'b1; state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign mem_req_o    = fetching;
  assign mem_addr_o   = ca_q;
  assign tally_vld_o  = (state_q == S_TALLY);
  assign tally_addr_o = ca_q;
  assign tally_tag_o  = tag_q;
  assign tally_word_o = word_q;
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign fault_code_o = code_q;
  assign ea_o         = ca_q;
  assign direct_o     = direct_q;
endmodule

// File: rtl/addr_chain_seq_chk.sv
module addr_chain_seq_chk #(
  parameter int AW         = 18,
  parameter int STEP_LIMIT = 4096
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ack_i,
  input logic          tally_vld_o,
  input logic          tally_done_i,
  input logic          done_o,
  input logic          fault_o,
  input logic [2:0]    fault_code_o,
  input logic [AW-1:0] ea_o
);
  localparam int CW = $clog2(STEP_LIMIT + 1) + 1;
  logic [CW-1:0] ack_cnt;
  logic [AW-1:0] last_fetch;
  logic          ack;

  assign ack = mem_req_o && mem_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_cnt    <= '0;
      last_fetch <= '0;
    end else begin
      if (done_o || fault_o) ack_cnt <= '0;
      else if (ack)          ack_cnt <= ack_cnt + 1'b1;
      if (ack) last_fetch <= mem_addr_o;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R13
  AST_ONE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o)); // R13
  AST_END_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |=> !(done_o || fault_o)); // R13
  AST_TALLY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tally_vld_o && !tally_done_i |=> tally_vld_o); // R11
  AST_TALLY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tally_vld_o && mem_req_o)); // R11
  AST_FETCH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack |-> ack_cnt < CW'(STEP_LIMIT)); // R9
  AST_LOCK_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && fault_code_o == 3'd1 |-> ack_cnt == CW'(STEP_LIMIT)); // R9
  AST_FAULT_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && (fault_code_o == 3'd2 || fault_code_o == 3'd3) |-> ea_o == last_fetch); // R8
endmodule

bind addr_chain_seq addr_chain_seq_chk #(.AW(AW), .STEP_LIMIT(STEP_LIMIT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_ack_i(mem_ack_i), .tally_vld_o(tally_vld_o), .tally_done_i(tally_done_i),
  .done_o(done_o), .fault_o(fault_o), .fault_code_o(fault_code_o), .ea_o(ea_o)
);

// File: tb/addr_chain_seq_tb.sv
`timescale 1ns/1ps
module addr_chain_seq_tb;
  localparam int AW = 18;
  localparam int WW = 36;
  localparam int LIM = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, rep = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [5:0] tag = '0;
  logic [WW-1:0] a_r = {18'd100, 18'd7};
  logic [WW-1:0] q_r = {18'd200, 18'd9};
  logic [8*AW-1:0] x_r;
  logic [AW-1:0] ic_r = 18'd40;
  logic mem_req, mem_ack = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_data = '0;
  logic tally_vld, tally_done = 1'b0;
  logic [AW-1:0] tally_addr, tally_ea = '0;
  logic [5:0] tally_tag;
  logic [WW-1:0] tally_word;
  logic done, fault, direct;
  logic [2:0] fcode;
  logic [AW-1:0] ea;

  logic [WW-1:0] mem [64];
  int vectors = 0, errors = 0, fetches = 0, tallies = 0;
  logic [5:0] seen_tally_tag;
  logic r_done, r_dir;
  logic [2:0] r_code;
  logic [AW-1:0] r_ea;

  always #10 clk = ~clk;

  initial for (int k = 0; k < 8; k++) x_r[k*AW +: AW] = AW'(3 * k + 1);

  addr_chain_seq #(.AW(AW), .WW(WW), .STEP_LIMIT(LIM)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .tag_i(tag),
    .repeat_i(rep), .a_i(a_r), .q_i(q_r), .x_i(x_r), .ic_i(ic_r),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack),
    .mem_data_i(mem_data), .tally_vld_o(tally_vld), .tally_addr_o(tally_addr),
    .tally_tag_o(tally_tag), .tally_word_o(tally_word), .tally_done_i(tally_done),
    .tally_ea_i(tally_ea), .done_o(done), .fault_o(fault), .fault_code_o(fcode),
    .ea_o(ea), .direct_o(direct)
  );

  function automatic logic [AW-1:0] defaddr(input int i);
    return AW'((i * 5 + 3) % 64);
  endfunction

  function automatic logic [WW-1:0] mw(input logic [AW-1:0] ad, input logic [5:0] tg);
    return {ad, 12'd0, tg};
  endfunction

  function automatic logic [AW-1:0] mv(input logic [3:0] td);
    if (td[3]) return AW'(3 * td[2:0] + 1);
    case (td[2:0])
      3'd1: return 18'd100;
      3'd2: return 18'd200;
      3'd4: return 18'd40;
      3'd5: return 18'd7;
      3'd6: return 18'd9;
      default: return 18'd0;
    endcase
  endfunction

  function automatic bit is_dir(input logic [3:0] td);
    return td == 4'd3 || td == 4'd7;
  endfunction

  task automatic mem_init();
    for (int i = 0; i < 64; i++) mem[i] = {defaddr(i), 18'd0};
  endtask

  // Memory responder: acknowledge one cycle after each request
  initial forever begin
    @(negedge clk);
    if (mem_req && !mem_ack) begin
      mem_ack = 1'b1; mem_data = mem[mem_addr[5:0]]; fetches++;
    end else mem_ack = 1'b0;
  end

  // Tally handler: completes with address + 5
  initial forever begin
    @(negedge clk);
    if (tally_vld && !tally_done) begin
      tally_done = 1'b1; tally_ea = tally_addr + 18'd5; seen_tally_tag = tally_tag; tallies++;
    end else tally_done = 1'b0;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [AW-1:0] ad, input logic [5:0] tg, input logic rp);
    int n = 0;
    @(negedge clk);
    start = 1'b1; addr = ad; tag = tg; rep = rp; fetches = 0; tallies = 0;
    @(negedge clk);
    start = 1'b0;
    while (!(done || fault) && n < 2000) begin @(negedge clk); n++; end
    r_done = done; r_code = fault ? fcode : 3'd0; r_ea = ea; r_dir = direct;
    if (n >= 2000) check("R13 end pulse", 0, 1);
  endtask

  task automatic expect_end(input string req, input logic [2:0] code,
                            input logic [AW-1:0] e, input logic d);
    check(req, {29'd0, r_code}, {29'd0, code});
    if (code == 3'd0) begin
      check(req, {31'd0, r_done}, 1);
      check(req, {14'd0, r_ea}, {14'd0, e});
      check(req, {31'd0, r_dir}, {31'd0, d});
    end else if (code != 3'd1) begin
      check(req, {14'd0, r_ea}, {14'd0, e});
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] fa, d;
    mem_init();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", {31'd0, done}, 0);
    check("R1 fault", {31'd0, fault}, 0);
    check("R1 req", {31'd0, mem_req}, 0);
    check("R1 tally", {31'd0, tally_vld}, 0);
    rst_n = 1'b1;

    // R2/R3 register mode sweep incl. 18-bit wrap
    foreach (fa[i]) ;
    for (int c = 0; c < 2; c++) begin
      for (int td = 0; td < 16; td++) begin
        d = (c == 0) ? 18'd10 : 18'h3FFFE;
        run(d, {2'd0, 4'(td)}, 1'b0);
        if (is_dir(4'(td))) expect_end("R3 direct", 3'd0, d, 1'b1);
        else expect_end("R2 R3 reg mode", 3'd0, d + mv(4'(td)), 1'b0);
      end
    end

    // R4 register-then-indirect sweep; R12 direct designators fault
    for (int td = 0; td < 16; td++) begin
      run(18'd5, {2'd1, 4'(td)}, 1'b0);
      if (is_dir(4'(td))) expect_end("R12 ri direct", 3'd4, 18'd5, 1'b0);
      else begin
        fa = 18'd5 + mv(4'(td));
        expect_end("R4 ri fetch", 3'd0, defaddr(int'(fa[5:0])), 1'b0);
        check("R4 fetch count", fetches, 1);
      end
    end

    // R5 indirect-then-register sweep with register-mode word
    for (int td = 0; td < 16; td++) begin
      run(18'd9, {2'd3, 4'(td)}, 1'b0);
      d = defaddr(9);
      if (is_dir(4'(td))) expect_end("R5 ir direct", 3'd0, d, 1'b1);
      else expect_end("R5 ir held", 3'd0, d + mv(4'(td)), 1'b0);
    end

    // R6 ir then ri
    mem[9] = mw(18'd12, {2'd1, 4'h9});
    run(18'd9, {2'd3, 4'hA}, 1'b0);
    expect_end("R6 ir-ri", 3'd0, defaddr(16) + mv(4'hA), 1'b0);
    check("R6 fetch count", fetches, 2);
    // R12 ir then ri with direct
    mem[9] = mw(18'd12, {2'd1, 4'h3});
    run(18'd9, {2'd3, 4'hA}, 1'b0);
    expect_end("R12 ir-ri direct", 3'd4, 18'd9, 1'b0);
    // R7 ir then ir
    mem[9] = mw(18'd12, {2'd3, 4'hB});
    run(18'd9, {2'd3, 4'hA}, 1'b0);
    expect_end("R7 ir-ir", 3'd0, defaddr(12) + mv(4'hB), 1'b0);
    // R8 ir then tally F2 / F3 / other
    mem[9] = mw(18'd12, {2'd2, 4'd6});
    run(18'd9, {2'd3, 4'hA}, 1'b0);
    expect_end("R8 F2", 3'd2, 18'd9, 1'b0);
    mem[9] = mw(18'd12, {2'd2, 4'd7});
    run(18'd9, {2'd3, 4'hA}, 1'b0);
    expect_end("R8 F3", 3'd3, 18'd9, 1'b0);
    mem[9] = mw(18'd12, {2'd2, 4'd0});
    run(18'd9, {2'd3, 4'hA}, 1'b0);
    expect_end("R8 tally as reg", 3'd0, 18'd12 + mv(4'hA), 1'b0);

    // R11 tally handoff after ri, and from the instruction tag
    mem[9] = mw(18'd12, {2'd2, 4'h8});
    run(18'd9, {2'd1, 4'h0}, 1'b0);
    expect_end("R11 tally ri", 3'd0, 18'd17, 1'b0);
    check("R11 tally count", tallies, 1);
    check("R11 tally tag", {26'd0, seen_tally_tag}, 32'h28);
    run(18'd30, {2'd2, 4'h4}, 1'b0);
    expect_end("R11 tally instr", 3'd0, 18'd35, 1'b0);
    check("R11 no fetch", fetches, 0);

    // R10 repeat: one indirection only
    mem[9] = mw(18'd12, {2'd1, 4'h0});
    run(18'd9, {2'd1, 4'h0}, 1'b1);
    expect_end("R10 repeat", 3'd0, 18'd12, 1'b0);
    check("R10 fetch count", fetches, 1);
    run(18'd9, {2'd1, 4'h0}, 1'b0);
    expect_end("R4 chained", 3'd0, defaddr(12), 1'b0);
    mem_init();

    // R9 lockup boundary: exactly LIM fetches ok, one more faults
    for (int i = 0; i < 7; i++) mem[50 + i] = mw(AW'(51 + i), {2'd1, 4'h0});
    mem[57] = mw(18'd20, 6'd0);
    run(18'd50, {2'd1, 4'h0}, 1'b0);
    expect_end("R9 at limit", 3'd0, 18'd20, 1'b0);
    check("R9 fetch count", fetches, LIM);
    mem[49] = mw(18'd50, {2'd1, 4'h0});
    run(18'd49, {2'd1, 4'h0}, 1'b0);
    expect_end("R9 lockup", 3'd1, 18'd0, 1'b0);
    check("R9 lockup fetches", fetches, LIM);

    // R9 vs R8 on the same acknowledge
    for (int i = 0; i < 7; i++) mem[40 + i] = mw(AW'(41 + i), {2'd3, 4'h1});
    mem[47] = mw(18'd5, {2'd2, 4'd6});
    run(18'd40, {2'd3, 4'h1}, 1'b0);
    expect_end("R8 R9 F2 at limit", 3'd2, 18'd47, 1'b0);
    check("R9 F2 fetches", fetches, LIM);
    mem[47] = mw(18'd5, {2'd3, 4'h1});
    run(18'd40, {2'd3, 4'h1}, 1'b0);
    expect_end("R9 ir lockup", 3'd1, 18'd0, 1'b0);
    check("R9 ir fetches", fetches, LIM);

    // R13 block returns to idle after fault
    run(18'd3, {2'd0, 4'h8}, 1'b0);
    expect_end("R13 restart", 3'd0, 18'd4, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule